// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a parameterised number of level-sensitive interrupt lines (a multiple of 32, up to 512) and folds them onto a small set of output lines, one line for each group of 64 inputs. Each input passes through a per-bit enable held in a mask word. A software-set word can force any input pending without its source line. The gated result is visible per 32-bit word in a read-only status bank. The group lines are copied onto exactly one of several output channels, chosen by a one-hot channel-control word. A single master-disable bit silences every output. A master-status word shows which groups have anything pending.

Software reaches the block through a plain 32-bit read/write bus with byte addresses whose two low bits are ignored. Every bank is numbered in reverse, so the last word of a bank serves inputs 0 to 31. The bank offsets grow with the register count `NREG = NUM_IRQ/32`. The output lines and the read data are registered.

Top module: `irq_steer_agg`

## Requirements
- R1: Word offsets are: channel control at 0x0, enable word n at 0x4+4n, force word n at 4·NREG+0x4+4n, status word n at 8·NREG+0x4+4n, master disable at 12·NREG+0x4, master status at 12·NREG+0x8. Channel control, enable words, force words and master disable reset to 0, and all outputs are low after reset.
- R2: Input i belongs to word index NREG−1−⌊i/32⌋ of each bank, at bit i mod 32.
- R3: A status word reads as (input lines OR force word) AND enable word.
- R4: An input whose enable bit is 0 never reaches the status bank or any output line.
- R5: A force bit written as 1 keeps its input pending while its source line is low, until the bit is written back to 0.
- R6: Group k (k = 0 … ⌈NUM_IRQ/64⌉−1) is pending when any enabled pending input in 64k … 64k+63 exists. Output irq_out[c·NOUT+k] follows it one clock after the inputs or registers change.
- R7: Outputs of channel c are driven only while channel control holds exactly one set bit, and that bit is bit c. A zero or multi-bit value holds every output low.
- R8: While master-disable bit 0 is 1, every output is low. The bit reads back at bit 0.
- R9: Master status bit k reports group k pending, regardless of master disable and channel control.
- R10: Reads of unmapped offsets return 0, and writes to them change nothing. The status bank and master status ignore writes. Channel-control bits at or above NUM_CHAN are not stored and read as 0.
- R11: bus_rdata loads at the clock edge where bus_sel is high and bus_wr is low, and holds its value at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | NUM_IRQ | Level-sensitive interrupt lines, bit i is input i |
| irq_out | output | NUM_CHAN·NOUT | Steered group lines, bit c·NOUT+k is group k on channel c |

## Verification
Single inputs are placed at the lowest word and at the top word of a group whose partner word does not exist. This separates a correct reversed mapping from a straight one and shows whether a lone odd word still raises its group. Enable-off, force-only and force-cleared patterns separate the raw line from the forced path and the gate. Random input, enable and force patterns are mixed with zero, one-hot, multi-bit and out-of-range channel values and with random master disable. They tell apart gating errors in the channel select, in the disable, and in the ungated master status, which must still report groups while the outputs are held low.

// File: rtl/irqsteer_pkg.sv
package irqsteer_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned GROUP_W  = 64;
   localparam int unsigned MAX_IRQ  = 512;
   localparam int unsigned MAX_OUT  = 8;
   localparam int unsigned MAX_CHAN = 32;
   localparam int unsigned IDX_W    = 5;

   typedef enum logic [2:0] {
      RK_CTRL,
      RK_ENAB,
      RK_FORCE,
      RK_STAT,
      RK_DIS,
      RK_MSTAT,
      RK_NONE
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e          kind;
      logic [IDX_W-1:0]   idx;
   } reg_sel_t;

   // Word offset to register bank and word index within the bank.
   function automatic reg_sel_t decode_word(input int unsigned woff,
                                            input int unsigned nreg);
      reg_sel_t s;
      s.kind = RK_NONE;
      s.idx  = '0;
      if (woff == 0) begin
         s.kind = RK_CTRL;
      end else if (woff <= nreg) begin
         s.kind = RK_ENAB;
         s.idx  = IDX_W'(woff - 1);
      end else if (woff <= 2 * nreg) begin
         s.kind = RK_FORCE;
         s.idx  = IDX_W'(woff - nreg - 1);
      end else if (woff <= 3 * nreg) begin
         s.kind = RK_STAT;
         s.idx  = IDX_W'(woff - 2 * nreg - 1);
      end else if (woff == 3 * nreg + 1) begin
         s.kind = RK_DIS;
      end else if (woff == 3 * nreg + 2) begin
         s.kind = RK_MSTAT;
      end
      return s;
   endfunction

endpackage

// File: rtl/irqsteer_status.sv
module irqsteer_status
   import irqsteer_pkg::*;
#(
   parameter int unsigned NREG = 4
) (
   input  logic [NREG*WORD_W-1:0] irq_src,
   input  logic [NREG*WORD_W-1:0] enab_flat,
   input  logic [NREG*WORD_W-1:0] force_flat,
   output logic [NREG*WORD_W-1:0] stat_flat
);

   // Word w serves inputs (NREG-1-w)*32 .. +31: the banks run in reverse.
   for (genvar w = 0; w < NREG; w++) begin : g_word
      localparam int unsigned SRC_LO = (NREG - 1 - w) * WORD_W;
      logic [WORD_W-1:0] raw_w;
      assign raw_w = irq_src[SRC_LO +: WORD_W];
      assign stat_flat[w*WORD_W +: WORD_W] =
         (raw_w | force_flat[w*WORD_W +: WORD_W]) & enab_flat[w*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/irqsteer_group.sv
module irqsteer_group
   import irqsteer_pkg::*;
#(
   parameter int unsigned NREG = 4,
   parameter int unsigned NOUT = 2
) (
   input  logic [NREG*WORD_W-1:0] stat_flat,
   output logic [NOUT-1:0]        grp_pend
);

   // Group k covers inputs 64k..64k+63, i.e. words NREG-1-2k and NREG-2-2k.
   for (genvar k = 0; k < NOUT; k++) begin : g_grp
      localparam int LO_WORD = int'(NREG) - 1 - 2 * k;
      localparam int HI_WORD = int'(NREG) - 2 - 2 * k;
      if (HI_WORD >= 0) begin : g_pair
         assign grp_pend[k] = (|stat_flat[LO_WORD*WORD_W +: WORD_W])
                            | (|stat_flat[HI_WORD*WORD_W +: WORD_W]);
      end else begin : g_single
         assign grp_pend[k] = |stat_flat[LO_WORD*WORD_W +: WORD_W];
      end
   end

endmodule

// File: rtl/irqsteer_regs.sv
module irqsteer_regs
   import irqsteer_pkg::*;
#(
   parameter int unsigned NREG   = 4,
   parameter int unsigned NCHAN  = 4,
   parameter int unsigned NOUT   = 2,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [WORD_W-1:0]      bus_wdata,
   input  logic [NREG*WORD_W-1:0] stat_flat,
   input  logic [NOUT-1:0]        grp_pend,
   output logic [NREG*WORD_W-1:0] enab_flat,
   output logic [NREG*WORD_W-1:0] force_flat,
   output logic [NCHAN-1:0]       ctrl_q,
   output logic                   dis_q,
   output logic [WORD_W-1:0]      bus_rdata
);

   reg_sel_t          sel;
   logic              wr_en;
   logic              rd_en;
   logic [WORD_W-1:0] rd_mux;
   logic              unused_addr_lsb;

   assign unused_addr_lsb = ^bus_addr[1:0];
   assign sel   = decode_word(int'(bus_addr[ADDR_W-1:2]), NREG);
   assign wr_en = bus_sel & bus_wr;
   assign rd_en = bus_sel & ~bus_wr;

   for (genvar w = 0; w < NREG; w++) begin : g_bank
      logic [WORD_W-1:0] enab_q;
      logic [WORD_W-1:0] force_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            enab_q <= '0;
         end else if (wr_en && sel.kind == RK_ENAB && sel.idx == IDX_W'(w)) begin
            enab_q <= bus_wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            force_q <= '0;
         end else if (wr_en && sel.kind == RK_FORCE && sel.idx == IDX_W'(w)) begin
            force_q <= bus_wdata;
         end
      end

      assign enab_flat[w*WORD_W +: WORD_W]  = enab_q;
      assign force_flat[w*WORD_W +: WORD_W] = force_q;

      AST_ENAB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && sel.kind == RK_ENAB && sel.idx == IDX_W'(w)) |=> enab_q == $past(bus_wdata)); // R1
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && sel.kind == RK_CTRL) begin
         ctrl_q <= bus_wdata[NCHAN-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q <= 1'b0;
      end else if (wr_en && sel.kind == RK_DIS) begin
         dis_q <= bus_wdata[0];
      end
   end

   always_comb begin
      rd_mux = '0;
      case (sel.kind)
         RK_CTRL:  rd_mux = WORD_W'(ctrl_q);
         RK_ENAB:  rd_mux = enab_flat[int'(sel.idx)*WORD_W +: WORD_W];
         RK_FORCE: rd_mux = force_flat[int'(sel.idx)*WORD_W +: WORD_W];
         RK_STAT:  rd_mux = stat_flat[int'(sel.idx)*WORD_W +: WORD_W];
         RK_DIS:   rd_mux = WORD_W'(dis_q);
         RK_MSTAT: rd_mux = WORD_W'(grp_pend);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_en) begin
         bus_rdata <= rd_mux;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (ctrl_q == '0 && !dis_q && enab_flat == '0 && force_flat == '0)); // R1

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel.kind == RK_NONE) |=> bus_rdata == '0); // R10

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(bus_rdata)); // R11

endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg
   import irqsteer_pkg::*;
#(
   parameter int unsigned NUM_IRQ  = 128,
   parameter int unsigned NUM_CHAN = 4,
   parameter int unsigned ADDR_W   = 8,
   localparam int unsigned NREG    = NUM_IRQ / WORD_W,
   localparam int unsigned NOUT    = (NUM_IRQ + GROUP_W - 1) / GROUP_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_sel,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [WORD_W-1:0]        bus_wdata,
   output logic [WORD_W-1:0]        bus_rdata,
   input  logic [NUM_IRQ-1:0]       irq_src,
   output logic [NUM_CHAN*NOUT-1:0] irq_out
);

   localparam int unsigned LAST_WOFF = 3 * NREG + 2;

   if (NUM_IRQ == 0 || NUM_IRQ % WORD_W != 0 || NUM_IRQ > MAX_IRQ) begin : g_bad_irq
      $error("NUM_IRQ must be a nonzero multiple of 32 not above 512");
   end
   if (NUM_CHAN == 0 || NUM_CHAN > MAX_CHAN) begin : g_bad_chan
      $error("NUM_CHAN must lie in 1..32");
   end
   if (NOUT > MAX_OUT) begin : g_bad_out
      $error("too many output groups");
   end
   if (ADDR_W < 3 || ADDR_W > 16 || (LAST_WOFF * 4) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NREG*WORD_W-1:0] enab_flat;
   logic [NREG*WORD_W-1:0] force_flat;
   logic [NREG*WORD_W-1:0] stat_flat;
   logic [NOUT-1:0]        grp_pend;
   logic [NUM_CHAN-1:0]    ctrl_q;
   logic                   dis_q;
   logic                   ctrl_single;
   logic                   route_en;
   logic [NUM_CHAN-1:0]    chan_act;

   irqsteer_regs #(
      .NREG   (NREG),
      .NCHAN  (NUM_CHAN),
      .NOUT   (NOUT),
      .ADDR_W (ADDR_W)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .stat_flat  (stat_flat),
      .grp_pend   (grp_pend),
      .enab_flat  (enab_flat),
      .force_flat (force_flat),
      .ctrl_q     (ctrl_q),
      .dis_q      (dis_q),
      .bus_rdata  (bus_rdata)
   );

   irqsteer_status #(
      .NREG (NREG)
   ) status_i (
      .irq_src    (irq_src),
      .enab_flat  (enab_flat),
      .force_flat (force_flat),
      .stat_flat  (stat_flat)
   );

   irqsteer_group #(
      .NREG (NREG),
      .NOUT (NOUT)
   ) group_i (
      .stat_flat (stat_flat),
      .grp_pend  (grp_pend)
   );

   // Exactly one channel bit set: nonzero and clearing the lowest set bit leaves zero.
   assign ctrl_single = (ctrl_q != '0) && ((ctrl_q & (ctrl_q - NUM_CHAN'(1))) == '0);
   assign route_en    = ctrl_single & ~dis_q;

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      logic [NOUT-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= '0;
         end else begin
            out_q <= (route_en && ctrl_q[c]) ? grp_pend : '0;
         end
      end
      assign irq_out[c*NOUT +: NOUT] = out_q;
      assign chan_act[c] = |out_q;
   end

   AST_DISABLE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dis_q) |-> irq_out == '0); // R8

   AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_act)); // R7

   AST_OUT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_out) |-> $past(|grp_pend)); // R6

endmodule

// File: tb/irq_steer_agg_tb_top.sv
module irq_steer_agg_tb_top;

   localparam int NI = 160;
   localparam int NC = 4;
   localparam int AW = 8;
   localparam int NR = NI / 32;
   localparam int NO = (NI + 63) / 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel = 1'b0;
   logic             wr = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [31:0]      wdata = '0;
   logic [31:0]      rdata;
   logic [NI-1:0]    src = '0;
   logic [NC*NO-1:0] irq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [31:0]   m_enab  [NR];
   logic [31:0]   m_force [NR];
   logic [NC-1:0] m_ctrl;
   logic          m_dis;

   always #5 clk = ~clk;

   irq_steer_agg #(
      .NUM_IRQ  (NI),
      .NUM_CHAN (NC),
      .ADDR_W   (AW)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (sel),
      .bus_wr    (wr),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_src   (src),
      .irq_out   (irq_out)
   );

   function automatic logic [AW-1:0] a_ctrl();         return AW'(0);                endfunction
   function automatic logic [AW-1:0] a_enab(int n);    return AW'(4 + 4*n);          endfunction
   function automatic logic [AW-1:0] a_force(int n);   return AW'(4*NR + 4 + 4*n);   endfunction
   function automatic logic [AW-1:0] a_stat(int n);    return AW'(8*NR + 4 + 4*n);   endfunction
   function automatic logic [AW-1:0] a_dis();          return AW'(12*NR + 4);        endfunction
   function automatic logic [AW-1:0] a_mstat();        return AW'(12*NR + 8);        endfunction

   // Per-input view: input i sits in word NR-1-i/32, bit i%32.
   function automatic logic pend_of(int i);
      int w = NR - 1 - i / 32;
      int b = i % 32;
      return (src[i] | m_force[w][b]) & m_enab[w][b];
   endfunction

   function automatic logic [31:0] exp_stat(int w);
      logic [31:0] r = '0;
      for (int i = 0; i < NI; i++)
         if (NR - 1 - i / 32 == w) r[i % 32] = pend_of(i);
      return r;
   endfunction

   function automatic logic [NO-1:0] exp_grp();
      logic [NO-1:0] g = '0;
      for (int i = 0; i < NI; i++)
         if (pend_of(i)) g[i / 64] = 1'b1;
      return g;
   endfunction

   function automatic logic [NC*NO-1:0] exp_out();
      logic [NC*NO-1:0] o = '0;
      if ($countones(m_ctrl) == 1 && !m_dis)
         for (int c = 0; c < NC; c++)
            if (m_ctrl[c]) o[c*NO +: NO] = exp_grp();
      return o;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk);
      sel = 1'b0;
      d = rdata;
   endtask

   task automatic set_enab(input int n, input logic [31:0] v);
      bus_wr(a_enab(n), v); m_enab[n] = v;
   endtask
   task automatic set_force(input int n, input logic [31:0] v);
      bus_wr(a_force(n), v); m_force[n] = v;
   endtask
   task automatic set_ctrl(input logic [31:0] v);
      bus_wr(a_ctrl(), v); m_ctrl = v[NC-1:0];
   endtask
   task automatic set_dis(input logic v);
      bus_wr(a_dis(), 32'(v)); m_dis = v;
   endtask
   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic check_all();
      logic [31:0] d;
      for (int w = 0; w < NR; w++) begin
         bus_rd(a_stat(w), d);
         chk("R3 status word", d, exp_stat(w));
      end
      bus_rd(a_mstat(), d);
      chk("R9 master status", d, 32'(exp_grp()));
      bus_rd(a_dis(), d);
      chk("R8 disable readback", d, 32'(m_dis));
      chk("R7 steered outputs", 32'(irq_out), 32'(exp_out()));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] held;
      void'($urandom(32'd20240611));
      for (int w = 0; w < NR; w++) begin m_enab[w] = '0; m_force[w] = '0; end
      m_ctrl = '0; m_dis = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      chk("R1 outputs after reset", 32'(irq_out), 32'h0);
      bus_rd(a_ctrl(), d);     chk("R1 ctrl reset", d, 32'h0);
      bus_rd(a_enab(0), d);    chk("R1 enable reset", d, 32'h0);
      bus_rd(a_force(NR-1), d); chk("R1 force reset", d, 32'h0);
      bus_rd(a_dis(), d);      chk("R1 disable reset", d, 32'h0);

      // R1 layout: write distinct values, read them back at their offsets
      set_ctrl(32'h2);
      for (int w = 0; w < NR; w++) set_enab(w, 32'hFFFF_FFFF);
      set_force(2, 32'h0000_0000);
      bus_wr(a_force(1), 32'hA5A5_0001); bus_rd(a_force(1), d);
      chk("R1 force word offset", d, 32'hA5A5_0001);
      bus_wr(a_force(1), 32'h0);
      bus_rd(a_ctrl(), d); chk("R1 ctrl offset", d, 32'h2);

      // R2 / R6: input 37 -> word NR-2, bit 5, group 0 on channel 1
      src = '0; src[37] = 1'b1; settle();
      bus_rd(a_stat(NR-2), d); chk("R2 input 37 word", d, 32'h0000_0020);
      chk("R6 group 0 on channel 1", 32'(irq_out), 32'(1 << (1*NO + 0)));

      // R2 / R6: input NI-1 -> word 0 bit 31, lone-word group NO-1
      src = '0; src[NI-1] = 1'b1; settle();
      bus_rd(a_stat(0), d); chk("R2 top input word", d, 32'h8000_0000);
      chk("R6 lone-word group", 32'(irq_out), 32'(1 << (1*NO + NO-1)));

      // R4: enable off blocks it
      set_enab(0, 32'h7FFF_FFFF); settle();
      bus_rd(a_stat(0), d); chk("R4 blocked status", d, 32'h0);
      chk("R4 blocked output", 32'(irq_out), 32'h0);
      set_enab(0, 32'hFFFF_FFFF);

      // R5: force input 0 while its line is low
      src = '0;
      set_force(NR-1, 32'h1); settle();
      bus_rd(a_stat(NR-1), d); chk("R5 forced status", d, 32'h1);
      chk("R5 forced output", 32'(irq_out), 32'(1 << (1*NO)));
      repeat (4) @(negedge clk);
      chk("R5 force persists", 32'(irq_out), 32'(1 << (1*NO)));
      set_force(NR-1, 32'h0); settle();
      chk("R5 force cleared", 32'(irq_out), 32'h0);

      // R7: zero and multi-bit channel values silence outputs
      src[100] = 1'b1;
      set_ctrl(32'h0); settle();
      chk("R7 zero ctrl", 32'(irq_out), 32'h0);
      set_ctrl(32'h3); settle();
      chk("R7 multi-bit ctrl", 32'(irq_out), 32'h0);
      set_ctrl(32'h4); settle();
      chk("R7 channel 2", 32'(irq_out), 32'(1 << (2*NO + 1)));

      // R10: ctrl bits above NUM_CHAN dropped
      set_ctrl(32'h0000_0018); settle();
      bus_rd(a_ctrl(), d); chk("R10 ctrl upper bits", d, 32'h8);
      chk("R10 upper bits ignored in steering", 32'(irq_out), 32'(1 << (3*NO + 1)));

      // R8 / R9: disable silences, master status still reports
      set_dis(1'b1); settle();
      chk("R8 disabled outputs", 32'(irq_out), 32'h0);
      bus_rd(a_mstat(), d); chk("R9 status under disable", d, 32'h2);
      bus_rd(a_dis(), d); chk("R8 disable readback", d, 32'h1);
      set_dis(1'b0); settle();

      // R10: unmapped and read-only locations
      bus_wr(AW'(12*NR + 12), 32'hDEAD_BEEF);
      bus_rd(AW'(12*NR + 12), d); chk("R10 unmapped read", d, 32'h0);
      bus_rd(AW'(8'hFC), d);      chk("R10 high unmapped read", d, 32'h0);
      bus_wr(a_stat(NR-4), 32'hFFFF_FFFF);
      bus_rd(a_stat(NR-4), d);    chk("R10 status write ignored", d, exp_stat(NR-4));
      bus_wr(a_mstat(), 32'hFF);
      bus_rd(a_mstat(), d);       chk("R10 master status write ignored", d, 32'(exp_grp()));
      chk("R10 outputs unchanged", 32'(irq_out), 32'(exp_out()));

      // R11: read data holds when no read is issued
      bus_rd(a_stat(NR-4), held);
      src[100] = 1'b0; src[64] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 rdata holds", rdata, held);

      // Random patterns
      for (int it = 0; it < 60; it++) begin
         int r;
         for (int w = 0; w < NR; w++) src[w*32 +: 32] = $urandom() & $urandom() & $urandom();
         for (int w = 0; w < NR; w++) set_enab(w, $urandom() & $urandom());
         for (int w = 0; w < NR; w++) set_force(w, $urandom() & $urandom() & $urandom() & $urandom());
         r = $urandom_range(0, 5);
         if (r == 0)      set_ctrl(32'h0);
         else if (r == 5) set_ctrl($urandom());
         else             set_ctrl(32'(1) << $urandom_range(0, NC-1));
         set_dis($urandom_range(0, 4) == 0);
         settle();
         check_all();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule